// File: doc/BRIEF.md
# Multi-Thread Gate Control Scheduler

This block is a time-aware egress gate scheduler for a switch. All ports share one linear table of gate control entries. Each entry holds a duration, a one-hot set of destination ports and a mask of traffic classes whose gates are closed. Up to eight cyclic execution threads walk this table. A thread owns a contiguous stretch of entries given by its start address and its end index. It also has a start offset, counted from a common base time.

After a start command the scheduler leaves STOPPED and enters ARMED. An enabled thread in IDLE goes to WAIT, or straight to EXEC if its start time has already come. It goes from WAIT to EXEC once the unit time counter `time_now` reaches `base_time` plus its offset. In EXEC the thread shows entries one after another. Each entry is held for its duration, counted in strobes of `unit_tick`, which mark one 200 ns unit. After its end index the thread wraps back to its start address. The scheduler moves from ARMED to RUNNING when the first thread launches. A stop command returns every thread to IDLE and the scheduler to STOPPED on the next edge, and rewinds each thread's pointer to its start address.

For each port, the block forms the gate-close mask as the OR of the masks of all executing threads whose current entry names that port. While no thread is executing, every gate stays open.

Top module: `gcs_scheduler`

## Requirements
- R1: After reset, `sts_stopped` is 1, `sts_started` and `sts_running` are 0, and every bit of `gate_close` is 0 (gate open).
- R2: A `cmd_start` pulse while stopped sets `sts_started` to 1 and clears `sts_stopped` after one edge. A `cmd_start` pulse while armed or running changes nothing.
- R3: A thread launches on the first edge, with the scheduler armed or running, at which `time_now >= base_time + offset`. Until a thread launches, `sts_running` is 0 and all gates are open.
- R4: Each entry stays on the outputs for exactly its duration in edges that carry `unit_tick`. Edges without `unit_tick` do not count. A duration of 0 is treated as 1.
- R5: After the entry at its end index, a thread continues at its start address.
- R6: Entry mask bit t closes traffic class t, at `gate_close[p*NUM_TC+t]`, for every port p whose bit p is set in the entry's port field.
- R7: Threads numbered above `act_last` never launch. `act_last` is the number of threads in use minus one.
- R8: A `cmd_stop` pulse makes the block stopped with all gates open after one edge. A later start begins each thread again at its start address.
- R9: When several threads execute at once, their masks for the same port are ORed.
- R10: `sts_running` becomes 1 on the edge at which the first thread launches, and only while started.
- R11: `cmd_stop` takes priority over `cmd_start` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_now | input | TIME_W | Free-running time counter in 200 ns units |
| unit_tick | input | 1 | One-cycle strobe per elapsed time unit |
| base_time | input | TIME_W | Common schedule base time |
| act_last | input | THR_W | Highest thread number in use |
| cmd_start | input | 1 | Start command pulse |
| cmd_stop | input | 1 | Stop command pulse |
| tbl_we | input | 1 | Entry table write enable |
| tbl_addr | input | IDX_W | Entry table write address |
| tbl_dur | input | DUR_W | Entry duration in units |
| tbl_ports | input | NUM_PORTS | Entry destination ports, bit p = port p |
| tbl_resv | input | NUM_TC | Entry gate-close mask, bit t = traffic class t |
| ep_we | input | 1 | Thread record write enable |
| ep_sel | input | THR_W | Thread record being written |
| ep_addr | input | IDX_W | Thread start address |
| ep_ofs | input | DUR_W | Thread start offset in units |
| ep_end | input | IDX_W | Thread end index |
| gate_close | output | NUM_PORTS*NUM_TC | Per-port closed-gate masks, port p at bits p*NUM_TC upward |
| sts_started | output | 1 | Scheduler armed or running |
| sts_stopped | output | 1 | Scheduler stopped |
| sts_running | output | 1 | At least one thread has launched |

## Verification
The hardest situation to reach is several threads executing at once on different periods and partly shared ports, with `unit_tick` arriving irregularly. Only then do the OR merge, the wrap at each end index and the tick-gated hold interact. The bench builds random partitions of the table across a random number of active threads, with small random durations, offsets and port sets. It runs each round with a different tick density and compares every cycle against a reference model. Directed cases cover a start and a stop in the same cycle, a repeated start, a restart after stop, and an unused thread whose port must stay open.

// File: rtl/gcs_pkg.sv
`timescale 1ns/1ps
package gcs_pkg;

    typedef enum logic [1:0] {
        SCH_STOPPED = 2'd0,
        SCH_ARMED   = 2'd1,
        SCH_RUNNING = 2'd2
    } sch_state_e;

    typedef enum logic [1:0] {
        THR_IDLE = 2'd0,
        THR_WAIT = 2'd1,
        THR_EXEC = 2'd2
    } thr_state_e;

endpackage

// File: rtl/gcs_entry_table.sv
`timescale 1ns/1ps
module gcs_entry_table #(
    parameter int DEPTH     = 64,
    parameter int DUR_W     = 19,
    parameter int NUM_PORTS = 5,
    parameter int NUM_TC    = 8,
    parameter int NRD       = 8,
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_addr,
    input  logic [DUR_W-1:0]         wr_dur,
    input  logic [NUM_PORTS-1:0]     wr_ports,
    input  logic [NUM_TC-1:0]        wr_resv,
    input  logic [NRD*IDX_W-1:0]     dur_idx,
    output logic [NRD*DUR_W-1:0]     dur_out,
    input  logic [NRD*IDX_W-1:0]     cur_idx,
    output logic [NRD*NUM_PORTS-1:0] ports_out,
    output logic [NRD*NUM_TC-1:0]    resv_out
);

    logic [DUR_W-1:0]     dur_mem   [DEPTH];
    logic [NUM_PORTS-1:0] ports_mem [DEPTH];
    logic [NUM_TC-1:0]    resv_mem  [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            dur_mem[wr_addr]   <= wr_dur;
            ports_mem[wr_addr] <= wr_ports;
            resv_mem[wr_addr]  <= wr_resv;
        end
    end

    // One duration read at each thread's next index, one attribute read at its current index.
    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign dur_out[r*DUR_W +: DUR_W]         = dur_mem[dur_idx[r*IDX_W +: IDX_W]];
        assign ports_out[r*NUM_PORTS +: NUM_PORTS] = ports_mem[cur_idx[r*IDX_W +: IDX_W]];
        assign resv_out[r*NUM_TC +: NUM_TC]       = resv_mem[cur_idx[r*IDX_W +: IDX_W]];
    end

endmodule

// File: rtl/gcs_thread.sv
`timescale 1ns/1ps
module gcs_thread #(
    parameter int IDX_W  = 6,
    parameter int DUR_W  = 19,
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sch_go,
    input  logic              halt,
    input  logic              unit_tick,
    input  logic [TIME_W-1:0] time_now,
    input  logic [TIME_W-1:0] base_time,
    input  logic [IDX_W-1:0]  start_addr,
    input  logic [IDX_W-1:0]  end_addr,
    input  logic [DUR_W-1:0]  start_ofs,
    input  logic [DUR_W-1:0]  nxt_dur,
    output logic              executing,
    output logic              launch,
    output logic [IDX_W-1:0]  cur_idx,
    output logic [IDX_W-1:0]  nxt_idx
);
    import gcs_pkg::*;

    thr_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [DUR_W-1:0] cnt_q;
    logic [TIME_W:0]  start_at;
    logic             due;

    assign start_at = {1'b0, base_time} + {{(TIME_W+1-DUR_W){1'b0}}, start_ofs};
    assign due      = {1'b0, time_now} >= start_at;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= THR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            THR_IDLE: if (!halt && sch_go && enable) state_d = due ? THR_EXEC : THR_WAIT;
            THR_WAIT: begin
                if (halt || !enable) state_d = THR_IDLE;
                else if (due)        state_d = THR_EXEC;
            end
            THR_EXEC: if (halt) state_d = THR_IDLE;
            default:  state_d = THR_IDLE;
        endcase
    end

    always_comb begin
        executing = (state_q == THR_EXEC);
        launch    = (state_d == THR_EXEC) && (state_q != THR_EXEC);
        cur_idx   = idx_q;
        if (state_q == THR_EXEC) nxt_idx = (idx_q == end_addr) ? start_addr : idx_q + 1'b1;
        else                     nxt_idx = start_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            cnt_q <= '0;
        end else if (halt) begin
            idx_q <= start_addr;
            cnt_q <= '0;
        end else if (launch) begin
            idx_q <= start_addr;
            cnt_q <= nxt_dur;
        end else if (state_q == THR_EXEC && unit_tick) begin
            if (cnt_q <= DUR_W'(1)) begin
                idx_q <= nxt_idx;
                cnt_q <= nxt_dur;
            end else begin
                cnt_q <= cnt_q - DUR_W'(1);
            end
        end
    end

endmodule

// File: rtl/gcs_gate_merge.sv
`timescale 1ns/1ps
module gcs_gate_merge #(
    parameter int NUM_THREADS = 8,
    parameter int NUM_PORTS   = 5,
    parameter int NUM_TC      = 8
) (
    input  logic [NUM_THREADS-1:0]           exec_vec,
    input  logic [NUM_THREADS*NUM_PORTS-1:0] ports_flat,
    input  logic [NUM_THREADS*NUM_TC-1:0]    resv_flat,
    output logic [NUM_PORTS*NUM_TC-1:0]      gate_close
);

    always_comb begin
        gate_close = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (exec_vec[t] && ports_flat[t*NUM_PORTS + p])
                    gate_close[p*NUM_TC +: NUM_TC] = gate_close[p*NUM_TC +: NUM_TC]
                                                   | resv_flat[t*NUM_TC +: NUM_TC];
            end
        end
    end

endmodule

// File: rtl/gcs_scheduler.sv
`timescale 1ns/1ps
module gcs_scheduler #(
    parameter int NUM_PORTS   = 5,
    parameter int NUM_TC      = 8,
    parameter int NUM_THREADS = 8,
    parameter int TBL_DEPTH   = 64,
    parameter int DUR_W       = 19,
    parameter int TIME_W      = 32,
    localparam int IDX_W      = $clog2(TBL_DEPTH),
    localparam int THR_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [TIME_W-1:0]           time_now,
    input  logic                        unit_tick,
    input  logic [TIME_W-1:0]           base_time,
    input  logic [THR_W-1:0]            act_last,
    input  logic                        cmd_start,
    input  logic                        cmd_stop,
    input  logic                        tbl_we,
    input  logic [IDX_W-1:0]            tbl_addr,
    input  logic [DUR_W-1:0]            tbl_dur,
    input  logic [NUM_PORTS-1:0]        tbl_ports,
    input  logic [NUM_TC-1:0]           tbl_resv,
    input  logic                        ep_we,
    input  logic [THR_W-1:0]            ep_sel,
    input  logic [IDX_W-1:0]            ep_addr,
    input  logic [DUR_W-1:0]            ep_ofs,
    input  logic [IDX_W-1:0]            ep_end,
    output logic [NUM_PORTS*NUM_TC-1:0] gate_close,
    output logic                        sts_started,
    output logic                        sts_stopped,
    output logic                        sts_running
);
    import gcs_pkg::*;

    logic [IDX_W-1:0] ep_addr_q [NUM_THREADS];
    logic [IDX_W-1:0] ep_end_q  [NUM_THREADS];
    logic [DUR_W-1:0] ep_ofs_q  [NUM_THREADS];

    logic [NUM_THREADS-1:0]           exec_vec, launch_vec;
    logic [NUM_THREADS*IDX_W-1:0]     cur_flat, nxt_flat;
    logic [NUM_THREADS*DUR_W-1:0]     dur_flat;
    logic [NUM_THREADS*NUM_PORTS-1:0] ports_flat;
    logic [NUM_THREADS*NUM_TC-1:0]    resv_flat;

    sch_state_e sch_q, sch_d;
    logic       sch_go;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_THREADS; t++) begin
                ep_addr_q[t] <= '0;
                ep_end_q[t]  <= '0;
                ep_ofs_q[t]  <= '0;
            end
        end else if (ep_we) begin
            ep_addr_q[ep_sel] <= ep_addr;
            ep_end_q[ep_sel]  <= ep_end;
            ep_ofs_q[ep_sel]  <= ep_ofs;
        end
    end

    gcs_entry_table #(
        .DEPTH(TBL_DEPTH), .DUR_W(DUR_W), .NUM_PORTS(NUM_PORTS),
        .NUM_TC(NUM_TC), .NRD(NUM_THREADS)
    ) u_table (
        .clk(clk), .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_dur(tbl_dur),
        .wr_ports(tbl_ports), .wr_resv(tbl_resv),
        .dur_idx(nxt_flat), .dur_out(dur_flat),
        .cur_idx(cur_flat), .ports_out(ports_flat), .resv_out(resv_flat)
    );

    for (genvar i = 0; i < NUM_THREADS; i++) begin : g_thr
        gcs_thread #(.IDX_W(IDX_W), .DUR_W(DUR_W), .TIME_W(TIME_W)) u_thr (
            .clk(clk), .rst_n(rst_n),
            .enable(THR_W'(i) <= act_last),
            .sch_go(sch_go), .halt(cmd_stop), .unit_tick(unit_tick),
            .time_now(time_now), .base_time(base_time),
            .start_addr(ep_addr_q[i]), .end_addr(ep_end_q[i]), .start_ofs(ep_ofs_q[i]),
            .nxt_dur(dur_flat[i*DUR_W +: DUR_W]),
            .executing(exec_vec[i]), .launch(launch_vec[i]),
            .cur_idx(cur_flat[i*IDX_W +: IDX_W]), .nxt_idx(nxt_flat[i*IDX_W +: IDX_W])
        );
    end

    gcs_gate_merge #(
        .NUM_THREADS(NUM_THREADS), .NUM_PORTS(NUM_PORTS), .NUM_TC(NUM_TC)
    ) u_merge (
        .exec_vec(exec_vec), .ports_flat(ports_flat),
        .resv_flat(resv_flat), .gate_close(gate_close)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sch_q <= SCH_STOPPED;
        else        sch_q <= sch_d;
    end

    always_comb begin
        sch_d = sch_q;
        unique case (sch_q)
            SCH_STOPPED: if (cmd_start && !cmd_stop) sch_d = SCH_ARMED;
            SCH_ARMED: begin
                if (cmd_stop)         sch_d = SCH_STOPPED;
                else if (|launch_vec) sch_d = SCH_RUNNING;
            end
            SCH_RUNNING: if (cmd_stop) sch_d = SCH_STOPPED;
            default:     sch_d = SCH_STOPPED;
        endcase
    end

    always_comb begin
        sch_go      = 1'b0;
        sts_started = 1'b0;
        sts_stopped = 1'b0;
        sts_running = 1'b0;
        unique case (sch_q)
            SCH_STOPPED: sts_stopped = 1'b1;
            SCH_ARMED: begin
                sch_go      = 1'b1;
                sts_started = 1'b1;
            end
            SCH_RUNNING: begin
                sch_go      = 1'b1;
                sts_started = 1'b1;
                sts_running = 1'b1;
            end
            default: sts_stopped = 1'b1;
        endcase
    end

endmodule

// File: rtl/gcs_scheduler_checker.sv
`timescale 1ns/1ps
module gcs_scheduler_checker #(
    parameter int GATE_W = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_start,
    input logic              cmd_stop,
    input logic [GATE_W-1:0] gate_close,
    input logic              sts_started,
    input logic              sts_stopped,
    input logic              sts_running
);

    p_open_when_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sts_stopped |-> gate_close == '0);

    p_start_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_stopped && cmd_start && !cmd_stop) |=> sts_started);

    p_closed_needs_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_close != '0) |-> sts_running);

    p_stop_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |=> (sts_stopped && gate_close == '0));

    p_running_started_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sts_running |-> (sts_started && !sts_stopped));

    p_run_from_armed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_running) |-> $past(sts_started));

    p_stop_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_stopped && cmd_stop) |=> !sts_started);

endmodule

bind gcs_scheduler gcs_scheduler_checker #(.GATE_W(NUM_PORTS*NUM_TC)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .gate_close(gate_close), .sts_started(sts_started),
    .sts_stopped(sts_stopped), .sts_running(sts_running)
);

// File: tb/gcs_scheduler_bench.sv
`timescale 1ns/1ps
module gcs_scheduler_bench;
    localparam int NP = 5, NTC = 8, NT = 8, DEPTH = 64, DW = 19, TW = 32, IW = 6, SW = 3;
    localparam int GW = NP*NTC;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n;
    logic [TW-1:0] time_now, base_time;
    logic          unit_tick;
    logic [SW-1:0] act_last;
    logic          cmd_start, cmd_stop;
    logic          tbl_we, ep_we;
    logic [IW-1:0] tbl_addr, ep_addr, ep_end;
    logic [DW-1:0] tbl_dur, ep_ofs;
    logic [NP-1:0] tbl_ports;
    logic [NTC-1:0] tbl_resv;
    logic [SW-1:0] ep_sel;
    logic [GW-1:0] gate_close;
    logic          sts_started, sts_stopped, sts_running;

    gcs_scheduler u_gcs_scheduler (
        .clk(clk), .rst_n(rst_n), .time_now(time_now), .unit_tick(unit_tick),
        .base_time(base_time), .act_last(act_last), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_dur(tbl_dur), .tbl_ports(tbl_ports),
        .tbl_resv(tbl_resv), .ep_we(ep_we), .ep_sel(ep_sel), .ep_addr(ep_addr),
        .ep_ofs(ep_ofs), .ep_end(ep_end), .gate_close(gate_close),
        .sts_started(sts_started), .sts_stopped(sts_stopped), .sts_running(sts_running)
    );

    int checks = 0, failures = 0, tick_pct = 100;

    // Reference model state built from the requirements
    int             m_dur [DEPTH];
    logic [NP-1:0]  m_ports [DEPTH];
    logic [NTC-1:0] m_resv [DEPTH];
    int m_addr [NT], m_ofs [NT], m_end [NT];
    int ms;
    bit mex [NT];
    int mcidx [NT], mcnt [NT];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0;
            for (int t = 0; t < NT; t++) begin mex[t] = 0; mcidx[t] = 0; mcnt[t] = 0; end
        end else if (cmd_stop) begin
            ms = 0;
            for (int t = 0; t < NT; t++) mex[t] = 0;
        end else begin
            bit go, launched;
            go = (ms != 0);
            launched = 0;
            for (int t = 0; t < NT; t++) begin
                if (!mex[t]) begin
                    if (go && t <= int'(act_last) &&
                        longint'(time_now) >= longint'(base_time) + longint'(m_ofs[t])) begin
                        mex[t] = 1; mcidx[t] = m_addr[t]; mcnt[t] = m_dur[mcidx[t]]; launched = 1;
                    end
                end else if (unit_tick) begin
                    if (mcnt[t] <= 1) begin
                        mcidx[t] = (mcidx[t] == m_end[t]) ? m_addr[t] : (mcidx[t] + 1) % DEPTH;
                        mcnt[t]  = m_dur[mcidx[t]];
                    end else mcnt[t]--;
                end
            end
            if (ms == 0 && cmd_start) ms = 1;
            else if (ms == 1 && launched) ms = 2;
        end
    end

    function automatic logic [GW-1:0] exp_gate();
        logic [GW-1:0] g = '0;
        for (int t = 0; t < NT; t++)
            if (mex[t])
                for (int p = 0; p < NP; p++)
                    if (m_ports[mcidx[t]][p]) g[p*NTC +: NTC] |= m_resv[mcidx[t]];
        return g;
    endfunction

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            if (unit_tick) time_now = time_now + 1;
            unit_tick = (($urandom % 100) < tick_pct);
            @(posedge clk);
            @(negedge clk);
            chk(gate_close == exp_gate(), "R4 R5 R6 R9 gate vs model", 64'(gate_close), 64'(exp_gate()));
            chk({sts_stopped, sts_started, sts_running} == {ms == 0, ms != 0, ms == 2},
                "R2 R10 status vs model", {sts_stopped, sts_started, sts_running},
                {ms == 0, ms != 0, ms == 2});
        end
    endtask

    task automatic wr_entry(input int a, input int d, input logic [NP-1:0] p, input logic [NTC-1:0] r);
        tbl_we = 1; tbl_addr = IW'(a); tbl_dur = DW'(d); tbl_ports = p; tbl_resv = r;
        m_dur[a] = d; m_ports[a] = p; m_resv[a] = r;
        @(posedge clk); @(negedge clk);
        tbl_we = 0;
    endtask

    task automatic wr_thread(input int t, input int a, input int o, input int e);
        ep_we = 1; ep_sel = SW'(t); ep_addr = IW'(a); ep_ofs = DW'(o); ep_end = IW'(e);
        m_addr[t] = a; m_ofs[t] = o; m_end[t] = e;
        @(posedge clk); @(negedge clk);
        ep_we = 0;
    endtask

    task automatic pulse(input bit s, input bit p);
        cmd_start = s; cmd_stop = p;
        step(1);
        cmd_start = 0; cmd_stop = 0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int a = 0; a < DEPTH; a++) begin m_dur[a] = 1; m_ports[a] = '0; m_resv[a] = '0; end
        for (int t = 0; t < NT; t++) begin m_addr[t] = 0; m_ofs[t] = 0; m_end[t] = 0; end
        rst_n = 0; time_now = 0; base_time = 0; unit_tick = 0; act_last = 0;
        cmd_start = 0; cmd_stop = 0; tbl_we = 0; ep_we = 0; tbl_addr = 0; tbl_dur = 0;
        tbl_ports = 0; tbl_resv = 0; ep_sel = 0; ep_addr = 0; ep_ofs = 0; ep_end = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(sts_stopped == 1, "R1 stopped after reset", 64'(sts_stopped), 1);
        chk(sts_started == 0, "R1 started after reset", 64'(sts_started), 0);
        chk(sts_running == 0, "R1 running after reset", 64'(sts_running), 0);
        chk(gate_close == '0, "R1 gates after reset", 64'(gate_close), 0);

        // Directed table: thread 0 on entries 0..2, thread 1 on entries 3..5
        wr_entry(0, 3, 5'b00001, 8'h0F);
        wr_entry(1, 1, 5'b00001, 8'hF0);
        wr_entry(2, 2, 5'b00011, 8'h01);
        wr_entry(3, 2, 5'b00010, 8'h80);
        wr_entry(4, 4, 5'b00010, 8'h00);
        wr_entry(5, 1, 5'b00110, 8'h3C);
        wr_thread(0, 0, 1, 2);
        wr_thread(1, 3, 5, 5);
        for (int t = 2; t < NT; t++) wr_thread(t, 5, 1, 5);
        base_time = 40; act_last = 1; tick_pct = 100;

        pulse(1, 1);
        chk(sts_stopped == 1, "R11 stop beats start", 64'(sts_stopped), 1);
        pulse(1, 0);
        chk(sts_started == 1 && sts_stopped == 0, "R2 start arms", {sts_started, sts_stopped}, 2'b10);
        while (time_now < 41) begin
            chk(sts_running == 0 && gate_close == '0, "R3 no launch before start time",
                {sts_running, gate_close}, 0);
            step(1);
        end
        chk(sts_running == 1, "R10 running at first launch", 64'(sts_running), 1);
        chk(gate_close == GW'(8'h0F), "R3 first entry on launch", 64'(gate_close), 64'h0F);
        step(200);
        pulse(1, 0);
        chk(sts_running == 1 && sts_started == 1, "R2 start ignored while running",
            {sts_running, sts_started}, 2'b11);
        pulse(0, 1);
        chk(sts_stopped == 1 && gate_close == '0, "R8 stop opens all gates",
            {sts_stopped, gate_close}, {1'b1, 40'h0});
        step(10);

        // Only thread 0 in use: port 1 traffic from thread 1 must never appear
        act_last = 0;
        wr_entry(2, 2, 5'b00001, 8'h01);
        pulse(1, 0);
        step(1);
        chk(gate_close == GW'(8'h0F), "R8 restart at start address", 64'(gate_close), 64'h0F);
        for (int i = 0; i < 250; i++) begin
            step(1);
            chk(gate_close[2*NTC-1:NTC] == '0, "R7 unused thread stays idle",
                64'(gate_close[2*NTC-1:NTC]), 0);
        end
        pulse(0, 1);

        // Random partitions and tick densities
        for (int r = 0; r < 6; r++) begin
            int k, last_end, nact;
            tick_pct = 40 + 12*r;
            nact = $urandom % NT;
            k = 0;
            last_end = 0;
            for (int t = 0; t <= nact; t++) begin
                int n = 1 + $urandom % 4;
                for (int e = 0; e < n; e++) begin
                    logic [NP-1:0] pm;
                    pm = NP'(1) << ($urandom % NP);
                    if ($urandom % 4 == 0) pm = pm | (NP'(1) << ($urandom % NP));
                    wr_entry(k + e, 1 + $urandom % 5, pm, NTC'($urandom));
                end
                wr_thread(t, k, 1 + $urandom % 30, k + n - 1);
                last_end = k + n - 1;
                k = k + n;
            end
            for (int t = nact + 1; t < NT; t++) wr_thread(t, $urandom % k, 1 + $urandom % 5, last_end);
            act_last = SW'(nact);
            base_time = time_now + 5;
            pulse(1, 0);
            step(400);
            pulse(0, 1);
            chk(sts_stopped == 1 && gate_close == '0, "R8 stop after random round",
                {sts_stopped, gate_close}, {1'b1, 40'h0});
            step(3);
        end

        summary();
        $finish;
    end

endmodule